// File: doc/BRIEF.md
# Open-Loop Voltage Vector Rotator

This block turns a rotating-frame voltage request into a two-axis stationary-frame command at the switching rate. Once per control period, software loads a magnitude, a starting angle and a per-update angle step. Every PWM update event then raises a one-cycle update strobe. At that strobe the block moves its phase forward by the step and produces the pair magnitude times cosine and magnitude times sine. This keeps the voltage vector turning between the slower software writes.

The phase is a 16-bit unsigned word in which full scale is one revolution. The step is a signed two's-complement phase increment applied once per update. Sine and cosine come from a quarter-wave table of 256 entries that is computed when the design is elaborated. The table is folded over the four quadrants. The two products are scaled back to signed 16-bit values. The output side is a plain valid pulse with no back-pressure: each update strobe yields exactly one `out_vld` cycle, a fixed three cycles later, and the consumer must take the data in that cycle. New outputs hold until the next valid pulse.

Top module: `vvec_rotator`

## Requirements
- R1: After reset, `out_vld` is low, both outputs are zero, and the active magnitude, phase and step are zero with no load pending. An update with no prior load therefore yields zero outputs.
- R2: An update strobe sampled at a clock edge in cycle n makes `out_vld` high for exactly cycle n+3. Strobes on consecutive cycles give consecutive valid cycles, one per strobe, in order.
- R3: A load strobe captures magnitude, angle and step into holding registers only. Without an update strobe, no valid pulse appears and the active phase does not move.
- R4: The first update after a load sets the phase to the loaded angle without adding a step. The loaded magnitude and step become active at that same update.
- R5: Every later update adds the active step to the phase modulo 2^16. The step is two's complement, so a negative step turns the vector backward, and the phase wraps through 0x0000.
- R6: `out_alpha` is the magnitude times the cosine of the phase and `out_beta` is the magnitude times the sine, each within 2 LSB of ideal. The angle used is phase bits [15:6] (quadrant in [15:14], table index in [13:6]), so phase bits [5:0] have no effect. The trigonometric values use 32767 as unity, and the product is divided by 32768.
- R7: At phases 0x0000, 0x4000, 0x8000 and 0xC000, one output is exactly zero. The other is exactly plus or minus floor(mag*32767/32768): (+,0), (0,+), (-,0) and (0,-) for (alpha, beta).
- R8: When load and update strobes coincide, the update uses the settings that were active or pending before that cycle. The new load stays pending and takes effect at the next update.
- R9: The magnitude is a 15-bit unsigned value, and a magnitude of zero gives zero on both outputs at every phase.
- R10: Division rounds toward zero. The outputs at phase p and at phase p+0x8000 (same magnitude) are therefore exact negatives of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for the three settings below |
| ld_mag | input | 15 | Unsigned voltage magnitude |
| ld_theta | input | 16 | Starting phase, full scale is one revolution |
| ld_step | input | 16 | Signed phase increment per update |
| upd_en | input | 1 | PWM update event strobe |
| out_vld | output | 1 | One-cycle pulse marking fresh outputs |
| out_alpha | output | 16 | Signed alpha-axis command |
| out_beta | output | 16 | Signed beta-axis command |

## Verification
The case that needs care is a software load arriving in the same cycle as a PWM update. The bench raises both strobes at the same clock edge once a vector is already turning. It expects the output three cycles later to follow the older settings. It then expects the next update alone to jump to the newly loaded angle and magnitude. Back-to-back update strobes, where the accumulator and all three pipeline stages are busy at once, are checked value by value against a model that tracks the phase independently.

// File: rtl/vvr_pkg.sv
package vvr_pkg;
  localparam int PHASE_W = 16;
  localparam int MAG_W   = 15;
  localparam int OUT_W   = 16;
  localparam int TAB_AW  = 8;

  localparam int     FRAC_B = 28;
  localparam longint PI_FX  = 64'sd843314857; // pi * 2^28

  // Quarter-wave sample k of 2^aw, scaled so sin(pi/2) maps to fs.
  function automatic int qsin(input int k, input int aw, input int fs);
    longint x, x2, term, acc;
    x    = (longint'(k) * PI_FX) >>> (aw + 1);
    x2   = (x * x) >>> FRAC_B;
    term = x;
    acc  = x;
    for (int n = 1; n <= 7; n++) begin
      term = -((term * x2) >>> FRAC_B) / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return int'((acc * longint'(fs) + (64'sd1 <<< (FRAC_B - 1))) >>> FRAC_B);
  endfunction
endpackage

// File: rtl/vvr_phase.sv
module vvr_phase #(
  parameter int PW = vvr_pkg::PHASE_W,
  parameter int MW = vvr_pkg::MAG_W,
  parameter int TW = vvr_pkg::TAB_AW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [MW-1:0] ld_mag,
  input  logic [PW-1:0] ld_theta,
  input  logic [PW-1:0] ld_step,
  input  logic          upd_en,
  output logic [TW-1:0] ang_o,
  output logic [MW-1:0] mag_o,
  output logic          vld_o
);
  logic [MW-1:0] hold_mag;
  logic [PW-1:0] hold_theta, hold_step, act_step, phase;
  logic          pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_mag   <= '0;
      hold_theta <= '0;
      hold_step  <= '0;
      act_step   <= '0;
      phase      <= '0;
      mag_o      <= '0;
      pend       <= 1'b0;
      vld_o      <= 1'b0;
    end else begin
      if (ld_en) begin
        hold_mag   <= ld_mag;
        hold_theta <= ld_theta;
        hold_step  <= ld_step;
      end
      if (upd_en) begin
        if (pend) begin
          phase    <= hold_theta;
          mag_o    <= hold_mag;
          act_step <= hold_step;
        end else begin
          phase <= phase + act_step;
        end
      end
      pend  <= ld_en | (pend & ~upd_en);
      vld_o <= upd_en;
    end
  end

  assign ang_o = phase[PW-1 -: TW];

  AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(phase)); // R3
  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !ld_en |=> !pend); // R4
  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && upd_en |=> pend); // R8
endmodule

// File: rtl/vvr_trig.sv
module vvr_trig #(
  parameter int AW = vvr_pkg::TAB_AW,
  parameter int OW = vvr_pkg::OUT_W,
  parameter int MW = vvr_pkg::MAG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW+1:0]        ang_i,
  input  logic [MW-1:0]        mag_i,
  input  logic                 vld_i,
  output logic signed [OW-1:0] sin_o,
  output logic signed [OW-1:0] cos_o,
  output logic [MW-1:0]        mag_o,
  output logic                 vld_o
);
  localparam int N  = 1 << AW;
  localparam int FS = (1 << (OW - 1)) - 1;

  logic [OW-2:0] qtab [0:N];

  for (genvar g = 0; g < N; g++) begin : g_tab
    localparam int VAL = vvr_pkg::qsin(g, AW, FS);
    assign qtab[g] = VAL[OW-2:0];
  end
  assign qtab[N] = (OW-1)'(FS);

  logic [1:0]           quad;
  logic [AW-1:0]        idx;
  logic [AW:0]          ridx;
  logic signed [OW-1:0] fwd, rev, s_nx, c_nx;

  assign quad = ang_i[AW+1:AW];
  assign idx  = ang_i[AW-1:0];
  assign ridx = (AW+1)'(N) - {1'b0, idx};
  assign fwd  = $signed({1'b0, qtab[idx]});
  assign rev  = $signed({1'b0, qtab[ridx]});

  always_comb begin
    unique case (quad)
      2'd0:    begin s_nx = fwd;  c_nx = rev;  end
      2'd1:    begin s_nx = rev;  c_nx = -fwd; end
      2'd2:    begin s_nx = -fwd; c_nx = -rev; end
      default: begin s_nx = -rev; c_nx = fwd;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
      mag_o <= '0;
      vld_o <= 1'b0;
    end else begin
      sin_o <= s_nx;
      cos_o <= c_nx;
      mag_o <= mag_i;
      vld_o <= vld_i;
    end
  end

  AST_TRIG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (sin_o != -(2 ** (OW - 1))) && (cos_o != -(2 ** (OW - 1)))); // R6
endmodule

// File: rtl/vvr_scale.sv
module vvr_scale #(
  parameter int OW = vvr_pkg::OUT_W,
  parameter int MW = vvr_pkg::MAG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [OW-1:0] sin_i,
  input  logic signed [OW-1:0] cos_i,
  input  logic [MW-1:0]        mag_i,
  input  logic                 vld_i,
  output logic signed [OW-1:0] alpha_o,
  output logic signed [OW-1:0] beta_o,
  output logic                 vld_o
);
  localparam int PRW = OW + MW + 1;
  localparam logic signed [PRW-1:0] BIAS = PRW'((1 << (OW - 1)) - 1);

  logic signed [MW:0]    mag_s;
  logic signed [PRW-1:0] pa, pb, ra, rb;

  assign mag_s = $signed({1'b0, mag_i});
  assign pa    = cos_i * mag_s;
  assign pb    = sin_i * mag_s;
  assign ra    = pa + (pa[PRW-1] ? BIAS : '0);
  assign rb    = pb + (pb[PRW-1] ? BIAS : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alpha_o <= '0;
      beta_o  <= '0;
      vld_o   <= 1'b0;
    end else begin
      if (vld_i) begin
        alpha_o <= OW'(ra >>> (OW - 1));
        beta_o  <= OW'(rb >>> (OW - 1));
      end
      vld_o <= vld_i;
    end
  end

  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i && (mag_i == '0) |=> (alpha_o == '0) && (beta_o == '0)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(alpha_o) && $stable(beta_o)); // R2
endmodule

// File: rtl/vvec_rotator.sv
module vvec_rotator #(
  parameter int PHASE_W = vvr_pkg::PHASE_W,
  parameter int MAG_W   = vvr_pkg::MAG_W,
  parameter int OUT_W   = vvr_pkg::OUT_W,
  parameter int TAB_AW  = vvr_pkg::TAB_AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic [MAG_W-1:0]        ld_mag,
  input  logic [PHASE_W-1:0]      ld_theta,
  input  logic [PHASE_W-1:0]      ld_step,
  input  logic                    upd_en,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_alpha,
  output logic signed [OUT_W-1:0] out_beta
);
  localparam int TW = TAB_AW + 2;

  logic [TW-1:0]           ang;
  logic [MAG_W-1:0]        mag0, mag1;
  logic                    v0, v1;
  logic signed [OUT_W-1:0] s1, c1;

  vvr_phase #(.PW(PHASE_W), .MW(MAG_W), .TW(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_mag(ld_mag),
    .ld_theta(ld_theta), .ld_step(ld_step), .upd_en(upd_en),
    .ang_o(ang), .mag_o(mag0), .vld_o(v0));

  vvr_trig #(.AW(TAB_AW), .OW(OUT_W), .MW(MAG_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .ang_i(ang), .mag_i(mag0), .vld_i(v0),
    .sin_o(s1), .cos_o(c1), .mag_o(mag1), .vld_o(v1));

  vvr_scale #(.OW(OUT_W), .MW(MAG_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .sin_i(s1), .cos_i(c1), .mag_i(mag1),
    .vld_i(v1), .alpha_o(out_alpha), .beta_o(out_beta), .vld_o(out_vld));

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> ##3 out_vld); // R2
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(upd_en, 3)); // R2
endmodule

// File: tb/sim_vvec_rotator.sv
module sim_vvec_rotator;
  logic        clk = 1'b0, rst_n = 1'b0, ld_en = 1'b0, upd_en = 1'b0;
  logic [14:0] ld_mag = '0;
  logic [15:0] ld_theta = '0, ld_step = '0;
  logic        out_vld;
  logic signed [15:0] out_alpha, out_beta;

  int checks = 0, fails = 0;
  bit done = 0;
  int          s_mag = 0, m_mag = 0;
  logic [15:0] s_theta = '0, s_step = '0, m_ph = '0, m_step = '0;
  bit          s_pend = 0;

  vvec_rotator u0 (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_mag(ld_mag),
    .ld_theta(ld_theta), .ld_step(ld_step), .upd_en(upd_en),
    .out_vld(out_vld), .out_alpha(out_alpha), .out_beta(out_beta));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ideal(input int mag, input logic [15:0] ph, input bit want_sin);
    real a;
    a = 2.0 * 3.14159265358979 * real'(ph[15:6]) / 1024.0;
    return $rtoi(real'(mag) * (want_sin ? $sin(a) : $cos(a)));
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model_upd();
    if (s_pend) begin
      m_ph = s_theta; m_mag = s_mag; m_step = s_step; s_pend = 0;
    end else m_ph = m_ph + m_step;
  endtask

  task automatic model_ld(input int mag, input logic [15:0] th, input logic [15:0] st);
    s_mag = mag; s_theta = th; s_step = st; s_pend = 1;
  endtask

  task automatic do_load(input int mag, input logic [15:0] th, input logic [15:0] st);
    @(negedge clk);
    ld_en = 1; ld_mag = 15'(mag); ld_theta = th; ld_step = st;
    model_ld(mag, th, st);
    @(negedge clk);
    ld_en = 0;
  endtask

  // Strobe an update, compare the result in cycle n+3 with the model.
  task automatic do_update(input string tag, output int a, output int b);
    int ea, eb;
    @(negedge clk);
    upd_en = 1;
    model_upd();
    ea = ideal(m_mag, m_ph, 0);
    eb = ideal(m_mag, m_ph, 1);
    @(negedge clk);
    upd_en = 0;
    chk(out_vld == 1'b0, "R2 early valid", int'(out_vld), 0);
    @(negedge clk);
    @(negedge clk);
    chk(out_vld == 1'b1, "R2 valid at n+3", int'(out_vld), 1);
    a = int'(out_alpha); b = int'(out_beta);
    chk(iabs(a - ea) <= 2, {tag, " R6 alpha"}, a, ea);
    chk(iabs(b - eb) <= 2, {tag, " R6 beta"}, b, eb);
    @(negedge clk);
    chk(out_vld == 1'b0, "R2 single pulse", int'(out_vld), 0);
  endtask

  task automatic t_reset();
    int a, b;
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0, "R1 reset valid", int'(out_vld), 0);
    chk(out_alpha == 0 && out_beta == 0, "R1 reset outputs", int'(out_alpha), 0);
    rst_n = 1;
    do_update("R1 update before load", a, b);
    chk(a == 0 && b == 0, "R1 zero magnitude after reset", a, 0);
  endtask

  task automatic t_load_hold();
    do_load(20000, 16'h0000, 16'h4000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(out_vld == 1'b0, "R3 load alone gives no valid", int'(out_vld), 0);
    end
  endtask

  task automatic t_quadrants();
    int a, b;
    do_update("R4 first update", a, b);
    chk(a == 19999 && b == 0, "R4 R7 phase 0000", a, 19999);
    do_update("R5 q1", a, b);
    chk(a == 0 && b == 19999, "R7 phase 4000", b, 19999);
    do_update("R5 q2", a, b);
    chk(a == -19999 && b == 0, "R7 phase 8000", a, -19999);
    do_update("R5 q3", a, b);
    chk(a == 0 && b == -19999, "R7 phase C000", b, -19999);
    do_update("R5 wrap", a, b);
    chk(a == 19999 && b == 0, "R5 wrap to 0000", a, 19999);
  endtask

  task automatic t_neg_step();
    int a, b;
    do_load(12345, 16'h1234, 16'hFA99);
    for (int i = 0; i < 6; i++) do_update("R5 negative step", a, b);
  endtask

  task automatic t_low_bits();
    int a1, b1, a2, b2;
    do_load(30000, 16'h1000, 16'h0000);
    do_update("R6 low bits zero", a1, b1);
    do_load(30000, 16'h103F, 16'h0000);
    do_update("R6 low bits set", a2, b2);
    chk(a1 == a2, "R6 bits 5:0 ignored alpha", a2, a1);
    chk(b1 == b2, "R6 bits 5:0 ignored beta", b2, b1);
  endtask

  task automatic t_symmetry();
    int a1, b1, a2, b2;
    do_load(32767, 16'h2ABC, 16'h8000);
    do_update("R10 first", a1, b1);
    do_update("R10 opposite", a2, b2);
    chk(a2 == -a1, "R10 alpha negated", a2, -a1);
    chk(b2 == -b1, "R10 beta negated", b2, -b1);
  endtask

  task automatic t_zero_mag();
    int a, b;
    do_load(0, 16'h1357, 16'h0101);
    for (int i = 0; i < 2; i++) begin
      do_update("R9 zero magnitude", a, b);
      chk(a == 0 && b == 0, "R9 outputs zero", iabs(a) + iabs(b), 0);
    end
  endtask

  task automatic t_coincide();
    int a, b, ea, eb;
    do_load(10000, 16'h0000, 16'h1000);
    do_update("R8 setup", a, b);
    @(negedge clk);
    ld_en = 1; upd_en = 1; ld_mag = 15'd25000; ld_theta = 16'h8000; ld_step = 16'h0000;
    model_upd();
    model_ld(25000, 16'h8000, 16'h0000);
    ea = ideal(m_mag, m_ph, 0);
    eb = ideal(m_mag, m_ph, 1);
    @(negedge clk);
    ld_en = 0; upd_en = 0;
    @(negedge clk);
    @(negedge clk);
    chk(out_vld == 1'b1, "R8 coincident update valid", int'(out_vld), 1);
    chk(iabs(int'(out_alpha) - ea) <= 2, "R8 old settings alpha", int'(out_alpha), ea);
    chk(iabs(int'(out_beta) - eb) <= 2, "R8 old settings beta", int'(out_beta), eb);
    do_update("R8 pending applied", a, b);
    chk(a == -24999 && b == 0, "R8 new load at next update", a, -24999);
  endtask

  task automatic t_b2b();
    int ea[3], eb[3];
    do_load(16000, 16'h0000, 16'h2000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      upd_en = 1;
      model_upd();
      ea[i] = ideal(m_mag, m_ph, 0);
      eb[i] = ideal(m_mag, m_ph, 1);
    end
    @(negedge clk);
    upd_en = 0;
    for (int i = 0; i < 3; i++) begin
      if (i > 0) @(negedge clk);
      chk(out_vld == 1'b1, "R2 back-to-back valid", int'(out_vld), 1);
      chk(iabs(int'(out_alpha) - ea[i]) <= 2, "R2 R5 back-to-back alpha", int'(out_alpha), ea[i]);
      chk(iabs(int'(out_beta) - eb[i]) <= 2, "R2 R5 back-to-back beta", int'(out_beta), eb[i]);
    end
    @(negedge clk);
    chk(out_vld == 1'b0, "R2 back-to-back end", int'(out_vld), 0);
  endtask

  initial begin
    t_reset();
    t_load_hold();
    t_quadrants();
    t_neg_step();
    t_low_bits();
    t_symmetry();
    t_zero_mag();
    t_coincide();
    t_b2b();
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule